// File: doc/BRIEF.md
# Lockable Watchdog Timer

The block is a 32-bit down-counting watchdog reached through a single-cycle register port. Software places a reload value in the load register and then sets the interrupt-enable bit. That write starts the counter. The bit cannot be cleared again until the chip is reset. Each time the count reaches zero, the counter reloads and the block latches a raw interrupt flag. The flag stays set until software writes the clear register. If the flag is still set at the next zero and reset generation is enabled, the block sends a one-cycle reset request to the system.

Software services the watchdog by rewriting the load register. This restarts the count from the new value but does not touch a pending interrupt. A lock register guards the configuration. Writing any value other than the key 32'h1ACC_E551 locks the block, and writing the key unlocks it.

The block has two states. In `ST_STOPPED` the counter holds. The transition START, an unlocked control write with bit 0 set, moves the block to `ST_COUNTING`. The block stays in `ST_COUNTING` until reset.

Register word addresses on `bus_addr` are:

| Address | Register | Access |
|---|---|---|
| 0 | load | read/write |
| 1 | current count | read-only |
| 2 | control | bit 0 interrupt enable, bit 1 reset enable |
| 3 | interrupt clear | write-only, reads 0 |
| 4 | raw flag | bit 0 |
| 5 | masked flag | bit 0 |
| 6 | lock | write any value; reads 1 while locked, 0 while unlocked |

All other addresses read 0. `bus_rdata` is combinational while `bus_sel` is high and `bus_wr` is low.

Top module: `wdog_timer`

## Requirements
- R1: After reset, load reads 32'hFFFF_FFFF, and count, control, raw flag, masked flag and lock all read 0. `irq_o` and `sys_rst_req_o` are low.
- R2: While stopped, the count holds at 0. A control write with bit 0 set loads the count from the load register on that edge. After that, the count drops by one every cycle.
- R3: In the cycle where a running count is 0, the next edge reloads the count from the load register and sets the raw flag (address 4, bit 0).
- R4: An unlocked write to the load register while running sets the count to the written value on that edge and leaves the raw flag unchanged.
- R5: An unlocked write of any value to address 3 clears the raw flag. No other register write clears it.
- R6: Interrupt enable is sticky. A control write with bit 0 clear leaves it set. Bit 1 takes the written value.
- R7: `irq_o` and the masked flag (address 5, bit 0) equal the raw flag ANDed with interrupt enable.
- R8: If the raw flag is already set when a timeout occurs and reset enable is 1, `sys_rst_req_o` is high for exactly the following cycle. With reset enable at 0, no request is made.
- R9: A write to address 6 of any value other than the key locks the block. While locked, writes to the load, control and clear registers are ignored, and the lock register reads 1.
- R10: A write of 32'h1ACC_E551 to address 6 unlocks the block. The lock register then reads 0 and writes take effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Masked interrupt |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Register writes act on the clock edge that ends the write cycle, so a read in the following cycle shows the new count, flag or lock state. A timeout in the cycle where the count reads 0 sets the raw flag and `irq_o` one edge later. The reset request appears one edge after that same timeout and lasts one cycle. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. It then compares `irq_o`, `sys_rst_req_o` and every read against that model on the next falling edge, which is when all of those results are due.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [0:0] {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } wd_state_e;

    localparam int unsigned IDX_LOAD   = 0;
    localparam int unsigned IDX_VALUE  = 1;
    localparam int unsigned IDX_CTRL   = 2;
    localparam int unsigned IDX_CLEAR  = 3;
    localparam int unsigned IDX_RAW    = 4;
    localparam int unsigned IDX_MASKED = 5;
    localparam int unsigned IDX_LOCK   = 6;

    localparam int unsigned CTRL_IEN_BIT = 0;
    localparam int unsigned CTRL_REN_BIT = 1;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4,
    parameter logic [DW-1:0] KEY = 32'h1ACC_E551
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] count_i,
    input  logic          raw_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] load_o,
    output logic          ien_o,
    output logic          ren_o,
    output logic          locked_o,
    output logic          load_wr_o,
    output logic          clear_wr_o,
    output logic          start_o
);
    logic [DW-1:0] load_q;
    logic          ien_q, ren_q, locked_q;
    logic          wr_any, wr_ok;
    logic          hit_load, hit_ctrl, hit_clear, hit_lock;

    assign wr_any    = sel & wr;
    assign wr_ok     = wr_any & ~locked_q;
    assign hit_load  = (addr == AW'(IDX_LOAD));
    assign hit_ctrl  = (addr == AW'(IDX_CTRL));
    assign hit_clear = (addr == AW'(IDX_CLEAR));
    assign hit_lock  = (addr == AW'(IDX_LOCK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q   <= '1;
            ien_q    <= 1'b0;
            ren_q    <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            if (wr_any && hit_lock)
                locked_q <= (wdata != KEY);
            if (wr_ok && hit_load)
                load_q <= wdata;
            if (wr_ok && hit_ctrl) begin
                ien_q <= ien_q | wdata[CTRL_IEN_BIT];
                ren_q <= wdata[CTRL_REN_BIT];
            end
        end
    end

    assign load_wr_o  = wr_ok & hit_load;
    assign clear_wr_o = wr_ok & hit_clear;
    assign start_o    = wr_ok & hit_ctrl & wdata[CTRL_IEN_BIT];
    assign load_o     = load_q;
    assign ien_o      = ien_q;
    assign ren_o      = ren_q;
    assign locked_o   = locked_q;

    always_comb begin
        rdata_o = '0;
        if (sel && !wr) begin
            case (addr)
                AW'(IDX_LOAD):   rdata_o = load_q;
                AW'(IDX_VALUE):  rdata_o = count_i;
                AW'(IDX_CTRL): begin
                    rdata_o[CTRL_IEN_BIT] = ien_q;
                    rdata_o[CTRL_REN_BIT] = ren_q;
                end
                AW'(IDX_RAW):    rdata_o[0] = raw_i;
                AW'(IDX_MASKED): rdata_o[0] = raw_i & ien_q;
                AW'(IDX_LOCK):   rdata_o[0] = locked_q;
                default:         rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          load_wr_i,
    input  logic [DW-1:0] load_wdata_i,
    input  logic [DW-1:0] load_i,
    output logic [DW-1:0] count_o,
    output logic          timeout_o
);
    wd_state_e     state_q, state_d;
    logic [DW-1:0] count_q, count_d;
    logic          at_zero;

    assign at_zero = (count_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state: START is the only transition; counting is held until reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (start_i) state_d = ST_COUNTING;
            ST_COUNTING: state_d = ST_COUNTING;
            default:     state_d = ST_STOPPED;
        endcase
    end

    // outputs: count update and timeout strobe
    always_comb begin
        count_d   = count_q;
        timeout_o = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                if (start_i) count_d = load_i;
            end
            ST_COUNTING: begin
                if (load_wr_i) begin
                    count_d = load_wdata_i;
                end else if (at_zero) begin
                    count_d   = load_i;
                    timeout_o = 1'b1;
                end else begin
                    count_d = count_q - 1'b1;
                end
            end
            default: count_d = '0;
        endcase
    end

    assign count_o = count_q;
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout_i,
    input  logic clear_i,
    input  logic ren_i,
    output logic raw_o,
    output logic rst_req_o
);
    logic raw_q, rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            rst_q <= timeout_i & raw_q & ren_i;
            if (timeout_i)
                raw_q <= 1'b1;
            else if (clear_i)
                raw_q <= 1'b0;
        end
    end

    assign raw_o     = raw_q;
    assign rst_req_o = rst_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4,
    parameter logic [DW-1:0] KEY = 32'h1ACC_E551
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic          sys_rst_req_o
);
    logic [DW-1:0] count_w, load_w;
    logic          raw_w, ien_w, ren_w, locked_w;
    logic          load_wr_w, clear_wr_w, start_w, timeout_w;

    wdog_regs #(.DW(DW), .AW(AW), .KEY(KEY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .count_i    (count_w),
        .raw_i      (raw_w),
        .rdata_o    (bus_rdata),
        .load_o     (load_w),
        .ien_o      (ien_w),
        .ren_o      (ren_w),
        .locked_o   (locked_w),
        .load_wr_o  (load_wr_w),
        .clear_wr_o (clear_wr_w),
        .start_o    (start_w)
    );

    wdog_counter #(.DW(DW)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_w),
        .load_wr_i    (load_wr_w),
        .load_wdata_i (bus_wdata),
        .load_i       (load_w),
        .count_o      (count_w),
        .timeout_o    (timeout_w)
    );

    wdog_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .timeout_i (timeout_w),
        .clear_i   (clear_wr_w),
        .ren_i     (ren_w),
        .raw_o     (raw_w),
        .rst_req_o (sys_rst_req_o)
    );

    assign irq_o = raw_w & ien_w;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_o,
    input logic          sys_rst_req_o,
    input logic          raw,
    input logic          ien,
    input logic          ren,
    input logic          locked,
    input logic          clear_wr,
    input logic [DW-1:0] load
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |=> !sys_rst_req_o); // R8
    AST_RST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |-> ($past(raw) && $past(ren))); // R8
    AST_IEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ien) |-> ien); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ien); // R7
    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw) && !raw) |-> $past(clear_wr)); // R5
    AST_LOCK_HOLDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> $stable(load)); // R9
endmodule

bind wdog_timer wdog_timer_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_o         (irq_o),
    .sys_rst_req_o (sys_rst_req_o),
    .raw           (raw_w),
    .ien           (ien_w),
    .ren           (ren_w),
    .locked        (locked_w),
    .clear_wr      (clear_wr_w),
    .load          (load_w)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
    localparam logic [31:0] KEY = 32'h1ACC_E551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_sel = 1'b0, b_wr = 1'b0;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic        irq_o, sys_rst_req_o;

    int checks = 0, errors = 0, pulses = 0, cycles = 0;
    bit done = 0;

    // behavioural reference model
    logic [31:0] m_load = '1, m_cnt = '0;
    bit m_run = 0, m_raw = 0, m_ien = 0, m_ren = 0, m_lock = 0, m_rst = 0;

    always #10 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata),
        .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
    );

    always @(posedge clk) begin : model
        bit wok, ldw, tmo, clr;
        if (!rst_n) begin
            m_load = '1; m_cnt = '0; m_run = 0; m_raw = 0;
            m_ien = 0; m_ren = 0; m_lock = 0; m_rst = 0;
        end else begin
            wok = b_sel && b_wr && !m_lock;
            ldw = wok && (b_addr == 4'd0);
            clr = wok && (b_addr == 4'd3);
            tmo = m_run && !ldw && (m_cnt == 0);
            m_rst = tmo && m_raw && m_ren;
            if (tmo) m_raw = 1; else if (clr) m_raw = 0;
            if (m_run) begin
                if (ldw) m_cnt = b_wdata;
                else if (m_cnt == 0) m_cnt = m_load;
                else m_cnt = m_cnt - 1;
            end else if (wok && b_addr == 4'd2 && b_wdata[0]) begin
                m_cnt = m_load;
                m_run = 1;
            end
            if (ldw) m_load = b_wdata;
            if (wok && b_addr == 4'd2) begin
                m_ien = m_ien | b_wdata[0];
                m_ren = b_wdata[1];
            end
            if (b_sel && b_wr && b_addr == 4'd6) m_lock = (b_wdata != KEY);
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_load;
            4'd1: return m_cnt;
            4'd2: return {30'd0, m_ren, m_ien};
            4'd4: return {31'd0, m_raw};
            4'd5: return {31'd0, m_raw & m_ien};
            4'd6: return {31'd0, m_lock};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the outputs against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cycles++;
            check({31'd0, irq_o}, {31'd0, m_raw & m_ien}, "R7 irq_o");
            check({31'd0, sys_rst_req_o}, {31'd0, m_rst}, "R8 sys_rst_req_o");
            if (sys_rst_req_o) pulses++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_sel = 0; b_wr = 0;
    endtask

    task automatic rdx(input logic [3:0] a, input logic [31:0] exp, input string tag);
        b_sel = 1; b_wr = 0; b_addr = a;
        #1;
        check(b_rdata, exp, tag);
        check(b_rdata, m_read(a), {tag, " model"});
        @(negedge clk);
        b_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual hung expected finish");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int p0;
        idle(3);
        rst_n = 1;
        // R1 reset values
        check({30'd0, irq_o, sys_rst_req_o}, 32'd0, "R1 outputs");
        rdx(4'd0, 32'hFFFF_FFFF, "R1 load");
        rdx(4'd1, 32'd0, "R1 count");
        rdx(4'd2, 32'd0, "R1 ctrl");
        rdx(4'd4, 32'd0, "R1 raw");
        rdx(4'd5, 32'd0, "R1 masked");
        rdx(4'd6, 32'd0, "R1 lock");
        // R2 stopped, then start
        wr(4'd0, 32'd20);
        idle(3);
        rdx(4'd1, 32'd0, "R2 stopped");
        wr(4'd2, 32'd1);
        rdx(4'd1, 32'd20, "R2 start");
        rdx(4'd1, 32'd19, "R2 decrement");
        // R3 first timeout
        idle(24);
        rdx(4'd4, 32'd1, "R3 raw set");
        rdx(4'd5, 32'd1, "R7 masked");
        // R5 clear
        wr(4'd3, 32'hDEAD_BEEF);
        rdx(4'd4, 32'd0, "R5 cleared");
        // R6 sticky enable, reset enable set
        wr(4'd2, 32'd2);
        rdx(4'd2, 32'd3, "R6 sticky");
        // R8 two timeouts without clear
        p0 = pulses;
        idle(50);
        check(32'(pulses - p0 > 0), 32'd1, "R8 pulse seen");
        // R4 reload keeps pending interrupt
        wr(4'd3, 32'd0);
        idle(25);
        rdx(4'd4, 32'd1, "R4 pending");
        wr(4'd0, 32'd100);
        rdx(4'd1, 32'd100, "R4 restart");
        rdx(4'd4, 32'd1, "R4 kept");
        // R9 lock
        wr(4'd6, 32'd0);
        rdx(4'd6, 32'd1, "R9 locked");
        wr(4'd0, 32'd7);
        rdx(4'd0, 32'd100, "R9 load held");
        wr(4'd3, 32'd0);
        rdx(4'd4, 32'd1, "R9 clear ignored");
        wr(4'd2, 32'd0);
        rdx(4'd2, 32'd3, "R9 ctrl held");
        // R10 unlock
        wr(4'd6, KEY);
        rdx(4'd6, 32'd0, "R10 unlocked");
        wr(4'd0, 32'd7);
        rdx(4'd0, 32'd7, "R10 load written");
        // R8 no request with reset disabled
        wr(4'd2, 32'd1);
        p0 = pulses;
        idle(150);
        check(32'(pulses - p0), 32'd0, "R8 disabled");
        check({31'd0, irq_o}, 32'd1, "R7 irq high");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule